// File: doc/BRIEF.md
# Sub-word Data Memory Interface

This block is a word-organised data RAM with byte and halfword access. The store path places the selected lane of the write data into the addressed word and keeps every other byte as it was. The load path picks one lane of the addressed word and sign-extends it to 32 bits, or returns the whole word.

The store width and the load width are set by two separate 2-bit selects. The low two address bits choose the lane, and the address bits above them choose the word. Writes take effect on the rising clock edge and reads are combinational. Misaligned accesses are not detected.

Memory contents have no named states; all behaviour is lane selection, merge and extraction. An active-low asynchronous reset clears every word.

Top module: `subword_dmem`

## Requirements
- R1: Width select code 00 is a full word. A store writes all 32 bits of wdata, and a load returns the whole word. addr[1:0] is ignored for these accesses.
- R2: Width select code 10 is a byte. A byte store with lane k = addr[1:0] replaces bits 8k+7:8k of the word with wdata[7:0]. For example, lane 01 replaces bits 15:8.
- R3: Width select code 01 is a halfword. A halfword store replaces bits 31:16 when addr[1] is 1 and bits 15:0 when addr[1] is 0, using wdata[15:0].
- R4: A byte or halfword store leaves every bit of the addressed word outside the selected lane unchanged.
- R5: A byte load returns the lane chosen by addr[1:0], sign-extended to 32 bits.
- R6: A halfword load returns the half chosen by addr[1], sign-extended to 32 bits.
- R7: Width select code 11 behaves as a full word access for both stores and loads.
- R8: While we is low, a clock edge leaves memory unchanged, whatever the address, data and store width.
- R9: addr[AW-1:2] is the word index. A store to one word does not change any other word.
- R10: While rst_n is low, all words are cleared to zero, and this reset does not wait for a clock edge. rdata reflects a new address or load width in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores occur on the rising edge |
| rst_n | input | 1 | Active-low asynchronous clear of all words |
| addr | input | AW | Byte address; bits [1:0] select the lane, the upper bits select the word |
| wdata | input | 32 | Store data, taken from its low lane for partial stores |
| we | input | 1 | Write enable |
| st_width | input | 2 | Store width: 00 word, 01 half, 10 byte, 11 word |
| ld_width | input | 2 | Load width: 00 word, 01 half, 10 byte, 11 word |
| rdata | output | 32 | Extracted and sign-extended load data |

## Verification
The bench builds the block with DEPTH = 16, which makes AW = 6. With this setting, byte address 63 is the highest word and highest lane, so the top of the index range and the last byte lane are exercised together with a low word. The small depth keeps the reset clear of the whole array cheap. It also lets one test show that a write to the top word leaves a low word intact. Sign extension is checked with lanes whose top bit is both set and clear.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
    typedef enum logic [1:0] {
        SZ_WORD = 2'b00,
        SZ_HALF = 2'b01,
        SZ_BYTE = 2'b10,
        SZ_WIDE = 2'b11
    } size_e;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned LANES   = WORD_W / 8;
endpackage

// File: rtl/dmem_store_merge.sv
module dmem_store_merge
    import dmem_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           lane,
    input  size_e                size,
    input  logic [WORD_W-1:0]    old_word,
    input  logic [WORD_W-1:0]    wdata,
    output logic [LANES-1:0]     lane_mask,
    output logic [WORD_W-1:0]    new_word
);
    logic [WORD_W-1:0] spread;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                lane_mask = 4'b0001 << lane;
                spread    = {LANES{wdata[7:0]}};
            end
            SZ_HALF: begin
                lane_mask = lane[1] ? 4'b1100 : 4'b0011;
                spread    = {2{wdata[15:0]}};
            end
            SZ_WORD, SZ_WIDE: begin
                lane_mask = 4'b1111;
                spread    = wdata;
            end
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign new_word[8*g +: 8] = lane_mask[g] ? spread[8*g +: 8] : old_word[8*g +: 8];
    end

    // R2
    byte_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_BYTE) |-> ($countones(lane_mask) == 1 && lane_mask[lane]));
    // R3
    half_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_HALF) |-> ($countones(lane_mask) == 2 && lane_mask[{lane[1], 1'b0}]));
    // R1
    word_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_WORD || size == SZ_WIDE) |-> ($countones(lane_mask) == LANES));
endmodule

// File: rtl/dmem_array.sv
module dmem_array
    import dmem_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IDX_W-1:0]     idx,
    input  logic [WORD_W-1:0]    wr_word,
    output logic [WORD_W-1:0]    rd_word
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wr_word;
        end
    end

    assign rd_word = mem[idx];

    // R4
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(idx)] == $past(wr_word)));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (mem[$past(idx)] == $past(rd_word)));
endmodule

// File: rtl/dmem_load_extract.sv
module dmem_load_extract
    import dmem_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           lane,
    input  size_e                size,
    input  logic [WORD_W-1:0]    word_in,
    output logic [WORD_W-1:0]    data_out
);
    logic [7:0]  byte_sel;
    logic [15:0] half_sel;

    always_comb begin
        byte_sel = word_in[8*lane +: 8];
        half_sel = word_in[16*lane[1] +: 16];
        unique case (size)
            SZ_BYTE:          data_out = {{24{byte_sel[7]}}, byte_sel};
            SZ_HALF:          data_out = {{16{half_sel[15]}}, half_sel};
            SZ_WORD, SZ_WIDE: data_out = word_in;
        endcase
    end

    // R5
    byte_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_BYTE) |-> (data_out[7:0] == word_in[8*lane +: 8]
                               && data_out[31:8] == {24{word_in[8*lane + 7]}}));
    // R6
    half_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_HALF) |-> (data_out[15:0] == word_in[16*lane[1] +: 16]
                               && data_out[31:16] == {16{word_in[16*lane[1] + 15]}}));
endmodule

// File: rtl/subword_dmem.sv
module subword_dmem
    import dmem_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = $clog2(DEPTH) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic [31:0]       wdata,
    input  logic              we,
    input  logic [1:0]        st_width,
    input  logic [1:0]        ld_width,
    output logic [31:0]       rdata
);
    localparam int unsigned IDX_W = AW - 2;

    logic [IDX_W-1:0]  word_idx;
    logic [1:0]        lane;
    logic [WORD_W-1:0] cur_word;
    logic [WORD_W-1:0] merged;
    logic [LANES-1:0]  mask;

    assign word_idx = addr[AW-1:2];
    assign lane     = addr[1:0];

    dmem_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .idx     (word_idx),
        .wr_word (merged),
        .rd_word (cur_word)
    );

    dmem_store_merge u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane      (lane),
        .size      (size_e'(st_width)),
        .old_word  (cur_word),
        .wdata     (wdata),
        .lane_mask (mask),
        .new_word  (merged)
    );

    dmem_load_extract u_extract (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane     (lane),
        .size     (size_e'(ld_width)),
        .word_in  (cur_word),
        .data_out (rdata)
    );

    // R4: bytes outside the mask keep their old value on a write
    for (genvar g = 0; g < LANES; g++) begin : g_keep
        keep_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && !mask[g]) |=> (u_array.mem[$past(word_idx)][8*g +: 8]
                                  == $past(cur_word[8*g +: 8])));
    end
endmodule

// File: tb/test_subword_dmem.sv
module test_subword_dmem;
    localparam int unsigned DEPTH = 16;
    localparam int unsigned AW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic          we = 1'b0;
    logic [1:0]    st_width = 2'b00;
    logic [1:0]    ld_width = 2'b00;
    logic [31:0]   rdata;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    subword_dmem #(.DEPTH(DEPTH), .AW(AW)) i_subword_dmem (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
        .st_width(st_width), .ld_width(ld_width), .rdata(rdata)
    );

    // entry: {is_load, width, addr, data_or_expect}
    localparam int NV = 24;
    localparam logic [40:0] VEC [NV] = '{
        {1'b0, 2'b00, 6'd8,  32'h11223344},  // R1 word store
        {1'b1, 2'b00, 6'd8,  32'h11223344},  // R1
        {1'b0, 2'b10, 6'd9,  32'hAABBCCDD},  // R2 lane 01 -> bits 15:8
        {1'b1, 2'b00, 6'd8,  32'h1122DD44},  // R2 R4
        {1'b1, 2'b10, 6'd9,  32'hFFFFFFDD},  // R5 negative
        {1'b1, 2'b10, 6'd8,  32'h00000044},  // R5 positive
        {1'b0, 2'b01, 6'd10, 32'h00008001},  // R3 upper half
        {1'b1, 2'b00, 6'd8,  32'h8001DD44},  // R3 R4
        {1'b1, 2'b01, 6'd10, 32'hFFFF8001},  // R6
        {1'b1, 2'b01, 6'd8,  32'hFFFFDD44},  // R6
        {1'b0, 2'b10, 6'd11, 32'h0000007F},  // R2 lane 11
        {1'b1, 2'b10, 6'd11, 32'h0000007F},  // R5
        {1'b1, 2'b00, 6'd8,  32'h7F01DD44},  // R4
        {1'b0, 2'b01, 6'd8,  32'h00001234},  // R3 lower half
        {1'b1, 2'b01, 6'd8,  32'h00001234},  // R6 positive
        {1'b1, 2'b00, 6'd8,  32'h7F011234},  // R4
        {1'b1, 2'b00, 6'd9,  32'h7F011234},  // R1 low bits ignored
        {1'b0, 2'b00, 6'd60, 32'hCAFEF00D},  // R9 top word
        {1'b1, 2'b10, 6'd63, 32'hFFFFFFCA},  // R5 top lane
        {1'b1, 2'b00, 6'd8,  32'h7F011234},  // R9 other word intact
        {1'b1, 2'b10, 6'd10, 32'h00000001},  // R5
        {1'b1, 2'b11, 6'd61, 32'hCAFEF00D},  // R7 load code 11
        {1'b0, 2'b11, 6'd14, 32'h01020304},  // R7 store code 11
        {1'b1, 2'b00, 6'd12, 32'h01020304}   // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_store(input logic [1:0] w, input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; st_width = w; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic do_load(input string req, input logic [1:0] w, input logic [AW-1:0] a,
                           input logic [31:0] exp);
        ld_width = w; addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    initial begin
        #50000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        do_load("R10", 2'b00, 6'd8, 32'h0);
        do_load("R10", 2'b00, 6'd60, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][40])
                do_load($sformatf("vec%0d", i), VEC[i][39:38], VEC[i][37:32], VEC[i][31:0]);
            else
                do_store(VEC[i][39:38], VEC[i][37:32], VEC[i][31:0]);
        end

        // R8: write enable low, clock edges pass
        @(negedge clk);
        we = 1'b0; st_width = 2'b10; addr = 6'd8; wdata = 32'hFFFFFFFF;
        repeat (2) @(negedge clk);
        do_load("R8", 2'b00, 6'd8, 32'h7F011234);

        // R10: combinational read of a new address in the same cycle
        do_load("R10", 2'b00, 6'd60, 32'hCAFEF00D);

        // R10: asynchronous clear, observed before any clock edge
        @(negedge clk);
        #1 rst_n = 1'b0;
        #0.5;
        do_load("R10", 2'b00, 6'd60, 32'h0);
        do_load("R10", 2'b00, 6'd8, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: byte store in last word does not touch word 0
        do_store(2'b10, 6'd62, 32'h00000080);
        do_load("R9", 2'b10, 6'd62, 32'hFFFFFF80);
        do_load("R9", 2'b00, 6'd0, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule